// File: doc/BRIEF.md
# SDRAM Column Command Legality Checker

This block sits beside a DDR2-style command bus and watches the active-low chip select, row strobe, column strobe and write enable pins on every rising clock edge. It recognises column read and column write commands, reports each one as a one-cycle strobe, and keeps track of the burst the command started. A mode input selects bursts of 4 beats or 8 beats. The bus moves two data beats per clock, so a 4-beat burst lasts 2 clocks and an 8-beat burst lasts 4 clocks.

Each column command is tested against four rules. The target bank must be open. Two column commands must be at least two clocks apart. A 4-beat burst may not be cut short. An 8-beat burst may be cut short only at its midpoint, two clocks after it started, and only by a command of the same direction. A command that breaks a rule produces a one-cycle error pulse with a code, and it also sets a sticky flag for that kind of error. The sticky flags stay set until a synchronous clear input is driven. The checker does not block anything, so every column command still restarts burst tracking, whether it is legal or not.

The block has no data-flow interface. All of its pins are plain control and status signals, and there is no back-pressure.

Top module: `col_cmd_checker`

## Requirements
- R1: A column command is a rising edge with cs_n=0, ras_n=1 and cas_n=0. In the cycle after that edge, rd_stb is 1 if we_n was 1 at the edge, and wr_stb is 1 if we_n was 0. Every other pin combination raises neither strobe.
- R2: A column command sampled while bank_open=0 raises err_pulse with err_code=0 (bank closed) and sets err_flags[0].
- R3: A column command that arrives one clock after the previous column command, while that burst is still running, gives err_code=1 (spacing) and sets err_flags[1].
- R4: With 4-beat bursts (burst8=0 when the earlier command was sampled), a command two or more clocks later raises no error.
- R5: During an 8-beat burst, a command of the same direction exactly two clocks after the burst started is legal and raises no error.
- R6: During an 8-beat burst, a command three clocks after it started gives err_code=2 (misaligned interrupt) and sets err_flags[2].
- R7: During an 8-beat burst, a command of the opposite direction exactly two clocks after it started gives err_code=3 (direction mismatch) and sets err_flags[3].
- R8: The burst length is captured when the command is sampled. A command that comes after the captured burst has finished (at least 2 clocks for 4 beats, at least 4 clocks for 8 beats) raises no error. A change of burst8 while a burst is running has no effect on that burst.
- R9: busy is 1 from the cycle after a column command until the cycle in which a new command would no longer fall inside the burst. That is 1 cycle for 4-beat bursts and 3 cycles for 8-beat bursts.
- R10: err_flags bits stay set until err_clr is sampled high. They are zero in the cycle after that edge, but an error detected at the same edge still sets its bit.
- R11: Each command reports at most one error, chosen in the order bank closed, then spacing, then direction mismatch, then misaligned interrupt.
- R12: After reset, strobes, busy, err_pulse and err_flags are 0, and the first column command after reset raises no spacing or interrupt error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| burst8 | input | 1 | Burst length mode: 1 = 8 beats, 0 = 4 beats |
| bank_open | input | 1 | The target bank is activated |
| err_clr | input | 1 | Synchronous clear of the sticky error flags |
| rd_stb | output | 1 | Column read seen at the previous edge |
| wr_stb | output | 1 | Column write seen at the previous edge |
| busy | output | 1 | A burst is in progress, so a new command now would interrupt it |
| err_pulse | output | 1 | The command at the previous edge broke a rule |
| err_code | output | 2 | Kind of the latest error (0 bank, 1 spacing, 2 misaligned, 3 mismatch) |
| err_flags | output | 4 | Sticky error bits, indexed by err_code |

## Verification
Most internal faults show up as the wrong error at the second command of a pair. If the elapsed-clock counter or the captured burst length is wrong, the gap at which a following command becomes legal moves: a clean gap reports an error, or a bad gap reports none, on the very edge of that command. If the captured direction is wrong, the midpoint command of an 8-beat burst is judged incorrectly. A fault in the length or the counter also changes the number of busy cycles, starting in the cycle right after the first command. The bench drives every pairing of burst mode, direction, gap of 1 to 5 clocks and bank state, so each of these faults is caught within the first few pairs.

// File: rtl/colchk_pkg.sv
package colchk_pkg;
  localparam int NUM_ERR = 4;

  typedef enum logic [1:0] {
    ERR_BANK    = 2'd0,
    ERR_SPACING = 2'd1,
    ERR_SPLIT   = 2'd2,
    ERR_MIXED   = 2'd3
  } err_kind_e;

  typedef struct packed {
    logic valid;
    logic is_rd;
  } col_cmd_t;
endpackage

// File: rtl/colchk_decode.sv
module colchk_decode
  import colchk_pkg::*;
(
  input  logic     cs_n,
  input  logic     ras_n,
  input  logic     cas_n,
  input  logic     we_n,
  output col_cmd_t cmd
);
  always_comb begin
    cmd.valid = !cs_n && ras_n && !cas_n;
    cmd.is_rd = we_n;
  end
endmodule

// File: rtl/colchk_tracker.sv
module colchk_tracker
  import colchk_pkg::*;
#(
  parameter int HALF_CLKS = 2,
  parameter int AGE_W     = $clog2(2 * HALF_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  col_cmd_t         cmd,
  input  logic             burst8,
  output logic [AGE_W-1:0] age,
  output logic             long_q,
  output logic             last_rd,
  output logic             in_burst
);
  localparam int FULL_CLKS = 2 * HALF_CLKS;
  localparam logic [AGE_W-1:0] AGE_SAT  = AGE_W'(FULL_CLKS);
  localparam logic [AGE_W-1:0] AGE_HALF = AGE_W'(HALF_CLKS);

  logic [AGE_W-1:0] age_q;
  logic [AGE_W-1:0] len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q   <= AGE_SAT;
      long_q  <= 1'b0;
      last_rd <= 1'b0;
    end else if (cmd.valid) begin
      age_q   <= AGE_W'(1);
      long_q  <= burst8;
      last_rd <= cmd.is_rd;
    end else if (age_q != AGE_SAT) begin
      age_q <= age_q + AGE_W'(1);
    end
  end

  assign len      = long_q ? AGE_SAT : AGE_HALF;
  assign age      = age_q;
  assign in_burst = age_q < len;

  // A new command always opens a burst window in the following cycle.
  assert_burst_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.valid |=> in_burst);
  // With no command the window never reopens once it has closed.
  assert_window_stays_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_burst && !cmd.valid) |=> !in_burst);
endmodule

// File: rtl/colchk_rules.sv
module colchk_rules
  import colchk_pkg::*;
#(
  parameter int HALF_CLKS = 2,
  parameter int TCCD      = 2,
  parameter int AGE_W     = $clog2(2 * HALF_CLKS + 1)
) (
  input  col_cmd_t         cmd,
  input  logic             bank_open,
  input  logic [AGE_W-1:0] age,
  input  logic             long_q,
  input  logic             last_rd,
  input  logic             in_burst,
  output logic             viol,
  output err_kind_e        kind
);
  localparam logic [AGE_W-1:0] AGE_HALF = AGE_W'(HALF_CLKS);
  localparam logic [AGE_W-1:0] AGE_TCCD = AGE_W'(TCCD);

  logic at_mid;

  assign at_mid = long_q && (age == AGE_HALF);

  always_comb begin
    viol = 1'b0;
    kind = ERR_BANK;
    if (cmd.valid) begin
      if (!bank_open) begin
        viol = 1'b1;
        kind = ERR_BANK;
      end else if (in_burst && age < AGE_TCCD) begin
        viol = 1'b1;
        kind = ERR_SPACING;
      end else if (in_burst && at_mid && (cmd.is_rd != last_rd)) begin
        viol = 1'b1;
        kind = ERR_MIXED;
      end else if (in_burst && !at_mid) begin
        viol = 1'b1;
        kind = ERR_SPLIT;
      end
    end
  end
endmodule

// File: rtl/colchk_errlog.sv
module colchk_errlog
  import colchk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               viol,
  input  err_kind_e          kind,
  input  logic               err_clr,
  output logic               err_pulse,
  output logic [1:0]         err_code,
  output logic [NUM_ERR-1:0] err_flags
);
  logic [NUM_ERR-1:0] hit;
  logic [NUM_ERR-1:0] flags_q;

  always_comb begin
    hit = '0;
    if (viol) hit[kind] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      err_code  <= 2'd0;
      flags_q   <= '0;
    end else begin
      err_pulse <= viol;
      if (viol) err_code <= kind;
      flags_q <= (err_clr ? '0 : flags_q) | hit;
    end
  end

  assign err_flags = flags_q;

  // Sticky bits only drop through an explicit clear.
  assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  // A pulse is always backed by the matching sticky bit.
  assert_pulse_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> flags_q[err_code]);
endmodule

// File: rtl/col_cmd_checker.sv
module col_cmd_checker
  import colchk_pkg::*;
#(
  parameter int HALF_CLKS = 2,
  parameter int TCCD      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       burst8,
  input  logic       bank_open,
  input  logic       err_clr,
  output logic       rd_stb,
  output logic       wr_stb,
  output logic       busy,
  output logic       err_pulse,
  output logic [1:0] err_code,
  output logic [3:0] err_flags
);
  localparam int AGE_W = $clog2(2 * HALF_CLKS + 1);

  col_cmd_t         cmd;
  logic [AGE_W-1:0] age;
  logic             long_q;
  logic             last_rd;
  logic             in_burst;
  logic             viol;
  err_kind_e        kind;

  colchk_decode u_decode (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cmd  (cmd)
  );

  colchk_tracker #(.HALF_CLKS(HALF_CLKS), .AGE_W(AGE_W)) u_tracker (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .burst8  (burst8),
    .age     (age),
    .long_q  (long_q),
    .last_rd (last_rd),
    .in_burst(in_burst)
  );

  colchk_rules #(.HALF_CLKS(HALF_CLKS), .TCCD(TCCD), .AGE_W(AGE_W)) u_rules (
    .cmd      (cmd),
    .bank_open(bank_open),
    .age      (age),
    .long_q   (long_q),
    .last_rd  (last_rd),
    .in_burst (in_burst),
    .viol     (viol),
    .kind     (kind)
  );

  colchk_errlog u_errlog (
    .clk      (clk),
    .rst_n    (rst_n),
    .viol     (viol),
    .kind     (kind),
    .err_clr  (err_clr),
    .err_pulse(err_pulse),
    .err_code (err_code),
    .err_flags(err_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_stb <= 1'b0;
      wr_stb <= 1'b0;
    end else begin
      rd_stb <= cmd.valid && cmd.is_rd;
      wr_stb <= cmd.valid && !cmd.is_rd;
    end
  end

  assign busy = in_burst;

  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_stb, wr_stb}));
  assert_pulse_needs_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (rd_stb || wr_stb));
  assert_strobe_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> busy);
  assert_closed_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_stb || wr_stb) && !$past(bank_open)) |-> (err_pulse && err_code == 2'd0));
  assert_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_stb || wr_stb) && $past(rd_stb || wr_stb) && $past(bank_open))
      |-> (err_pulse && err_code == 2'd1));
endmodule

// File: tb/col_cmd_checker_test.sv
`timescale 1ns/1ps
module col_cmd_checker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic burst8 = 1'b0, bank_open = 1'b1, err_clr = 1'b0;
  logic rd_stb, wr_stb, busy, err_pulse;
  logic [1:0] err_code;
  logic [3:0] err_flags;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  col_cmd_checker uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .burst8(burst8), .bank_open(bank_open), .err_clr(err_clr),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .busy(busy), .err_pulse(err_pulse),
    .err_code(err_code), .err_flags(err_flags)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Sets the pins at the falling edge, then samples 1 ns after the next rising edge.
  task automatic cycle(input logic c, input logic r, input logic a, input logic w,
                       input logic bl, input logic bk, input logic clr);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = a; we_n = w;
    burst8 = bl; bank_open = bk; err_clr = clr;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n, input logic clr);
    for (int i = 0; i < n; i++) cycle(1, 1, 1, 1, 0, 1, (i == 0) ? clr : 1'b0);
  endtask

  task automatic col(input logic is_rd, input logic bl, input logic bk, input logic clr);
    cycle(0, 1, 0, is_rd, bl, bk, clr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12: state right after reset
    chk("R12 rd_stb", rd_stb, 0);
    chk("R12 wr_stb", wr_stb, 0);
    chk("R12 busy", busy, 0);
    chk("R12 err_pulse", err_pulse, 0);
    chk("R12 err_flags", err_flags, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2, 0);
    col(1, 1, 1, 0);
    chk("R12 first cmd clean", err_pulse, 0);
    chk("R12 first cmd strobe", rd_stb, 1);
    idle(6, 0);

    // R1: every pin combination of the four command pins
    for (int p = 0; p < 16; p++) begin
      logic c, r, a, w, is_col;
      {c, r, a, w} = 4'(p);
      is_col = !c && r && !a;
      cycle(c, r, a, w, 0, 1, 0);
      chk("R1 rd_stb", rd_stb, int'(is_col && w));
      chk("R1 wr_stb", wr_stb, int'(is_col && !w));
      chk("R1 no error", err_pulse, 0);
      idle(5, 0);
    end

    // R2..R9, R11: pairs swept over mode, direction, gap and bank state
    for (int m = 0; m < 2; m++)
      for (int t1 = 0; t1 < 2; t1++)
        for (int g = 1; g <= 5; g++)
          for (int t2 = 0; t2 < 2; t2++)
            for (int b2 = 0; b2 < 2; b2++) begin
              int len, code;
              bit inb, pulse;
              len = (m != 0) ? 4 : 2;
              idle(6, 1);
              chk("R10 cleared", err_flags, 0);
              col(t1[0], m[0], 1, 0);
              chk("R1 first strobe", rd_stb, t1);
              chk("R9 busy after cmd", busy, 1);
              chk("R8 first clean", err_pulse, 0);
              for (int k = 1; k < g; k++) begin
                // opposite mode during the burst must not matter (R8)
                cycle(1, 1, 1, 1, !m[0], 1, 0);
                chk("R9 busy window", busy, int'((1 + k) < len));
              end
              col(t2[0], !m[0], b2[0], 0);
              inb = g < len;
              pulse = 1; code = 0;
              if (b2 == 0) code = 0;
              else if (inb && g < 2) code = 1;
              else if (inb && m == 1 && g == 2 && t1 != t2) code = 3;
              else if (inb && !(m == 1 && g == 2)) code = 2;
              else pulse = 0;
              chk("R11 pulse", err_pulse, int'(pulse));
              if (pulse) begin
                if (code == 0) chk("R2 code", err_code, 0);
                else if (code == 1) chk("R3 code", err_code, 1);
                else if (code == 2) chk("R6 code", err_code, 2);
                else chk("R7 code", err_code, 3);
              end else if (m == 1 && g == 2) chk("R5 mid same dir", err_pulse, 0);
              else if (m == 0) chk("R4 short burst", err_pulse, 0);
              else chk("R8 after burst", err_pulse, 0);
              chk("R11 flags", err_flags, pulse ? (1 << code) : 0);
              chk("R1 second strobe", wr_stb, int'(t2 == 0));
            end

    // R10: sticky hold, clear, clear with a coincident error
    idle(6, 1);
    col(1, 0, 1, 0);
    col(0, 0, 1, 0);
    chk("R3 spacing", err_code, 1);
    for (int i = 0; i < 3; i++) begin
      idle(1, 0);
      chk("R10 hold", err_flags, 2);
      chk("R10 pulse gone", err_pulse, 0);
    end
    idle(1, 1);
    chk("R10 clear", err_flags, 0);
    idle(5, 0);
    col(0, 0, 0, 1);
    chk("R10 clear and set", err_flags, 1);
    chk("R2 bank closed", err_code, 0);
    idle(1, 1);
    chk("R10 clear again", err_flags, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule